// File: doc/BRIEF.md
# Four-Way Vector Interleave Unit

This block takes four source vectors of `VL_BITS` bits each and writes four destination vectors in which matching elements of the sources sit side by side. Destination `r` is built only from the `r`-th quarter of every source. Each group of four adjacent destination elements holds one element index taken in turn from source 0, 1, 2 and 3. The element width is chosen per operation from 8, 16, 32, 64 or 128 bits. A 2-bit size code picks the narrow widths and a separate wide-mode bit picks 128 bits.

A caller presents the operands with `in_valid` high. Exactly one clock later the unit raises `out_valid` with the four results registered. Some width and vector-length combinations cannot be performed. For those the unit still answers one cycle later, but it raises `out_undef` and drives all four results to zero. The latency never depends on the operand values.

Control is a two-state machine. `ST_IDLE` means no result is being presented. `ST_DONE` means the registered outputs hold a fresh result and `out_valid` is high. The transitions are: `T_ACCEPT` (ST_IDLE to ST_DONE on `in_valid`), `T_STREAM` (ST_DONE stays in ST_DONE on `in_valid`), `T_DRAIN` (ST_DONE to ST_IDLE without `in_valid`) and `T_WAIT` (ST_IDLE stays in ST_IDLE without `in_valid`).

Top module: `zip4_unit`

## Requirements
- R1: The element width is `8 << size_code` when `wide_mode` is 0: code 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. When `wide_mode` is 1 the width is 128 bits, whatever `size_code` holds.
- R2: Let W be the element width and Q = VL_BITS/(4·W). Element 4q+s of destination r (bits `(4q+s)·W` upward) equals element r·Q+q of source s, for every r and s in 0..3 and every q in 0..Q-1. All elements of all four destinations are written.
- R3: The operation is undefined when VL_BITS < 4·W. It is also undefined when the width is 64 and the maximum vector length is below 256, or when the width is 128 and the maximum vector length is below 512. The maximum vector length equals VL_BITS.
- R4: For an undefined operation, `out_undef` is 1 and all four destinations are zero in the result cycle. For a defined operation, `out_undef` is 0.
- R5: `out_valid` is high in the cycle after every cycle with `in_valid` high, and low in the cycle after every cycle with `in_valid` low. This holds for any operand data.
- R6: In a cycle after `in_valid` was low, the destinations and `out_undef` keep their previous values, even if the sources change.
- R7: While `rst_n` is low at a clock edge, the unit clears `out_valid`, `out_undef` and all destinations to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and width selection are valid this cycle |
| size_code | input | 2 | Element width code: 8 << code bits |
| wide_mode | input | 1 | Selects 128-bit elements and overrides size_code |
| src0 | input | VL_BITS | Source vector 0 |
| src1 | input | VL_BITS | Source vector 1 |
| src2 | input | VL_BITS | Source vector 2 |
| src3 | input | VL_BITS | Source vector 3 |
| out_valid | output | 1 | Registered result is present |
| out_undef | output | 1 | Result belongs to an undefined operation |
| dst0 | output | VL_BITS | Destination vector 0 |
| dst1 | output | VL_BITS | Destination vector 1 |
| dst2 | output | VL_BITS | Destination vector 2 |
| dst3 | output | VL_BITS | Destination vector 3 |

## Verification
The bench sweeps every size code with and without wide mode on two instances, one 512 bits wide and one 128 bits wide. In the narrow instance the 64-bit and 128-bit cases are undefined. A design that flagged by the wrong threshold, or that leaked permuted data while flagging, would show non-zero destinations or a wrong flag there. An ascending byte pattern exposes any swap of the group index with the source index, or a quarter offset taken from the wrong destination. It also shows a 128-bit mode that fell back to the size code. After each result the sources are scrambled with `in_valid` low, which catches a register that loads without the strobe or a valid that sticks high.

// File: rtl/zip4_pkg.sv
package zip4_pkg;

    localparam int NUM_SRC    = 4;
    localparam int NUM_WIDTHS = 5;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } zip_state_e;

    function automatic int elem_bits(input int idx);
        return 8 << idx;
    endfunction

endpackage

// File: rtl/zip4_decode.sv
module zip4_decode
    import zip4_pkg::*;
#(
    parameter int VL_BITS     = 512,
    parameter int MAX_VL_BITS = VL_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            size_code,
    input  logic                  wide_mode,
    output logic [NUM_WIDTHS-1:0] width_sel,
    output logic                  undef
);

    function automatic logic [NUM_WIDTHS-1:0] fit_mask();
        logic [NUM_WIDTHS-1:0] m;
        for (int i = 0; i < NUM_WIDTHS; i++) begin
            m[i] = (VL_BITS >= NUM_SRC * elem_bits(i));
        end
        return m;
    endfunction

    localparam logic [NUM_WIDTHS-1:0] FITS = fit_mask();
    localparam logic DWORD_OK = (MAX_VL_BITS >= 256);
    localparam logic QWORD_OK = (MAX_VL_BITS >= 512);

    always_comb begin
        width_sel = '0;
        if (wide_mode) begin
            width_sel[NUM_WIDTHS-1] = 1'b1;
        end else begin
            width_sel[size_code] = 1'b1;
        end
    end

    always_comb begin
        undef = ~|(width_sel & FITS)
              | (width_sel[3] & ~DWORD_OK)
              | (width_sel[4] & ~QWORD_OK);
    end

    // R1
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(width_sel) == 1);

endmodule

// File: rtl/zip4_permute.sv
module zip4_permute
    import zip4_pkg::*;
#(
    parameter int VL_BITS = 512
) (
    input  logic [NUM_SRC-1:0][VL_BITS-1:0] src,
    input  logic [NUM_WIDTHS-1:0]           width_sel,
    output logic [NUM_SRC-1:0][VL_BITS-1:0] dst
);

    logic [NUM_SRC-1:0][VL_BITS-1:0] cand [NUM_WIDTHS];

    for (genvar wi = 0; wi < NUM_WIDTHS; wi++) begin : g_width
        localparam int W     = 8 << wi;
        localparam int QUADS = VL_BITS / (NUM_SRC * W);
        if (QUADS > 0) begin : g_fit
            logic [NUM_SRC-1:0][VL_BITS-1:0] pv;
            for (genvar r = 0; r < NUM_SRC; r++) begin : g_dst
                for (genvar q = 0; q < QUADS; q++) begin : g_grp
                    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
                        assign pv[r][(NUM_SRC*q+s)*W +: W] = src[s][(r*QUADS+q)*W +: W];
                    end
                end
            end
            assign cand[wi] = pv;
        end else begin : g_none
            assign cand[wi] = '0;
        end
    end

    always_comb begin
        dst = '0;
        for (int wi = 0; wi < NUM_WIDTHS; wi++) begin
            if (width_sel[wi]) begin
                dst = dst | cand[wi];
            end
        end
    end

endmodule

// File: rtl/zip4_unit.sv
module zip4_unit
    import zip4_pkg::*;
#(
    parameter int VL_BITS = 512
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         size_code,
    input  logic               wide_mode,
    input  logic [VL_BITS-1:0] src0,
    input  logic [VL_BITS-1:0] src1,
    input  logic [VL_BITS-1:0] src2,
    input  logic [VL_BITS-1:0] src3,
    output logic               out_valid,
    output logic               out_undef,
    output logic [VL_BITS-1:0] dst0,
    output logic [VL_BITS-1:0] dst1,
    output logic [VL_BITS-1:0] dst2,
    output logic [VL_BITS-1:0] dst3
);

    logic [NUM_WIDTHS-1:0]           width_sel;
    logic                            undef;
    logic [NUM_SRC-1:0][VL_BITS-1:0] src_bus;
    logic [NUM_SRC-1:0][VL_BITS-1:0] perm;
    logic [NUM_SRC-1:0][VL_BITS-1:0] dst_q;
    logic                            undef_q;
    zip_state_e                      state_q, state_d;

    assign src_bus = {src3, src2, src1, src0};

    zip4_decode #(
        .VL_BITS     (VL_BITS),
        .MAX_VL_BITS (VL_BITS)
    ) i_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_code (size_code),
        .wide_mode (wide_mode),
        .width_sel (width_sel),
        .undef     (undef)
    );

    zip4_permute #(
        .VL_BITS (VL_BITS)
    ) i_permute (
        .src       (src_bus),
        .width_sel (width_sel),
        .dst       (perm)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = in_valid ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q   <= '0;
            undef_q <= 1'b0;
        end else if (in_valid) begin
            dst_q   <= undef ? '0 : perm;
            undef_q <= undef;
        end
    end

    assign out_valid = (state_q == ST_DONE);
    assign out_undef = undef_q;
    assign dst0      = dst_q[0];
    assign dst1      = dst_q[1];
    assign dst2      = dst_q[2];
    assign dst3      = dst_q[3];

    // R5
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R5
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dst0) && $stable(dst1) && $stable(dst2)
                       && $stable(dst3) && $stable(out_undef)));

    // R4
    undef_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> (dst0 == '0 && dst1 == '0 && dst2 == '0 && dst3 == '0));

    // R3
    wide_short_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_mode && (VL_BITS < 512)) |=> out_undef);

endmodule

// File: tb/test_zip4_unit.sv
module test_zip4_unit;

    localparam int CLK_PERIOD = 10;
    localparam int VL_W       = 512;
    localparam int VL_N       = 128;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [1:0]       size_code;
    logic             wide_mode;
    logic [VL_W-1:0]  drv [4];

    logic             val_w, und_w, val_n, und_n;
    logic [VL_W-1:0]  dw0, dw1, dw2, dw3;
    logic [VL_N-1:0]  dn0, dn1, dn2, dn3;

    logic [VL_W-1:0]  exp_w [4];
    logic [VL_W-1:0]  exp_n [4];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zip4_unit #(.VL_BITS(VL_W)) i_zip4_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .size_code(size_code), .wide_mode(wide_mode),
        .src0(drv[0]), .src1(drv[1]), .src2(drv[2]), .src3(drv[3]),
        .out_valid(val_w), .out_undef(und_w),
        .dst0(dw0), .dst1(dw1), .dst2(dw2), .dst3(dw3)
    );

    zip4_unit #(.VL_BITS(VL_N)) i_zip4_unit_narrow (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .size_code(size_code), .wide_mode(wide_mode),
        .src0(drv[0][VL_N-1:0]), .src1(drv[1][VL_N-1:0]),
        .src2(drv[2][VL_N-1:0]), .src3(drv[3][VL_N-1:0]),
        .out_valid(val_n), .out_undef(und_n),
        .dst0(dn0), .dst1(dn1), .dst2(dn2), .dst3(dn3)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [VL_W-1:0] act, input logic [VL_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic build_ref(input int vl, input int w, output logic [VL_W-1:0] e [4]);
        int quads;
        quads = vl / (4 * w);
        for (int r = 0; r < 4; r++) e[r] = '0;
        for (int r = 0; r < 4; r++)
            for (int q = 0; q < quads; q++)
                for (int s = 0; s < 4; s++)
                    for (int b = 0; b < w; b++)
                        e[r][(4*q+s)*w + b] = drv[s][(r*quads+q)*w + b];
    endtask

    task automatic fill(input int pat);
        for (int s = 0; s < 4; s++) begin
            if (pat == 0) begin
                for (int k = 0; k < VL_W/8; k++)
                    drv[s][k*8 +: 8] = 8'((s << 6) | (k & 63));
            end else begin
                for (int k = 0; k < VL_W/32; k++)
                    drv[s][k*32 +: 32] = $urandom;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [VL_W-1:0] held_w [4];
        logic [VL_W-1:0] held_n [4];
        int w;
        bit nu;

        rst_n = 1'b0; in_valid = 1'b0; size_code = 2'd0; wide_mode = 1'b0;
        for (int s = 0; s < 4; s++) drv[s] = '0;
        fill(1);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R7 reset state, even with in_valid high
        check(val_w == 1'b0 && val_n == 1'b0, "R7", "valid after reset", {val_n, val_w}, 0);
        check(und_w == 1'b0 && und_n == 1'b0, "R7", "undef after reset", {und_n, und_w}, 0);
        check((dw0|dw1|dw2|dw3) == '0, "R7", "wide dst after reset", dw0|dw1|dw2|dw3, 0);
        check((dn0|dn1|dn2|dn3) == '0, "R7", "narrow dst after reset",
              VL_W'(dn0|dn1|dn2|dn3), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int wm = 0; wm < 2; wm++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int pat = 0; pat < 3; pat++) begin
                    fill(pat);
                    wide_mode = wm[0];
                    size_code = sz[1:0];
                    in_valid  = 1'b1;
                    // R1 width mapping; wide mode overrides the code
                    w  = (wm == 1) ? 128 : (8 << sz);
                    nu = (4 * w > VL_N);
                    build_ref(VL_W, w, exp_w);
                    if (nu) begin
                        for (int r = 0; r < 4; r++) exp_n[r] = '0;
                    end else begin
                        build_ref(VL_N, w, exp_n);
                    end
                    @(negedge clk);
                    // R5 one cycle latency
                    check(val_w == 1'b1, "R5", "wide valid", VL_W'(val_w), 1);
                    check(val_n == 1'b1, "R5", "narrow valid", VL_W'(val_n), 1);
                    // R3 / R4 undefined flag
                    check(und_w == 1'b0, "R3", "wide undef", VL_W'(und_w), 0);
                    check(und_n == nu, "R3", "narrow undef", VL_W'(und_n), VL_W'(nu));
                    // R1 / R2 interleave contents, R4 zero when undefined
                    check(dw0 == exp_w[0], "R2", "wide dst0", dw0, exp_w[0]);
                    check(dw1 == exp_w[1], "R2", "wide dst1", dw1, exp_w[1]);
                    check(dw2 == exp_w[2], "R2", "wide dst2", dw2, exp_w[2]);
                    check(dw3 == exp_w[3], "R2", "wide dst3", dw3, exp_w[3]);
                    check(VL_W'(dn0) == exp_n[0], nu ? "R4" : "R2", "narrow dst0", VL_W'(dn0), exp_n[0]);
                    check(VL_W'(dn1) == exp_n[1], nu ? "R4" : "R2", "narrow dst1", VL_W'(dn1), exp_n[1]);
                    check(VL_W'(dn2) == exp_n[2], nu ? "R4" : "R2", "narrow dst2", VL_W'(dn2), exp_n[2]);
                    check(VL_W'(dn3) == exp_n[3], nu ? "R4" : "R2", "narrow dst3", VL_W'(dn3), exp_n[3]);
                    held_w = exp_w;
                    held_n = exp_n;
                    in_valid  = 1'b0;
                    wide_mode = ~wide_mode;
                    size_code = ~size_code;
                    fill(1);
                    @(negedge clk);
                    // R5 valid drops, R6 outputs hold
                    check(val_w == 1'b0 && val_n == 1'b0, "R5", "valid drop", {val_n, val_w}, 0);
                    check(dw0 == held_w[0] && dw3 == held_w[3], "R6", "wide hold", dw0 ^ dw3, held_w[0] ^ held_w[3]);
                    check(VL_W'(dn1) == held_n[1] && VL_W'(dn2) == held_n[2], "R6", "narrow hold",
                          VL_W'(dn1 ^ dn2), held_n[1] ^ held_n[2]);
                    check(und_n == nu, "R6", "undef hold", VL_W'(und_n), VL_W'(nu));
                end
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule